// File: doc/BRIEF.md
# Hot-swap status, sticky fault and alert register core

This block holds the digital monitoring and control state of a hot-swap controller. It samples three asynchronous logic inputs: an enable pin, an external fault pin, and the comparator result of a general-purpose pin. It keeps four byte-wide registers. A live status register shows the present input levels. A sticky fault register records events until software clears them. An alert-enable register selects which faults pull the active-low alert output. A control register sets the mode of the general-purpose pin and holds the gate command for the pass device.

Software reaches the registers over a simple parallel bus. A write takes effect at the clock edge on which `reg_wr` is high. A read is requested with `reg_rd`, and its data comes back one cycle later on `rd_data`, qualified by `rd_valid`. Register addresses are: 0 status (read-only), 1 fault, 2 alert-enable, 3 control. The general-purpose pin appears as an output-enable and an output value. When the pin is enabled, the external pad drives `gp_out`; otherwise the pad floats.

Top module: `hsc_monitor_regs`

## Requirements
- R1: During and after a synchronous reset (`rst_n` low at a clock edge), the status, fault and alert-enable registers read 0x00. The control register reads 0x08 when `dflt_on` is high and 0x00 when it is low. `alert_n` is high.
- R2: Status bit 4 follows the level of `en_pin` through a two-flop synchronizer, so it shows the new level within two clocks. A read requested on cycle n returns its data with `rd_valid` high on cycle n+1.
- R3: Any change of the synchronized enable level, rising or falling, sets fault bit 4 one clock after status bit 4 changes.
- R4: A synchronized high on `flt_pin` sets fault bit 7. Status bit 7 shows the live synchronized level of `flt_pin`.
- R5: When control bits 7:6 equal 2'b11 (input mode), a synchronized high `gp_cmp` sets both status bit 6 and fault bit 6. When `gp_cmp` falls again, status bit 6 clears and fault bit 6 stays set. In every other mode, status bit 6 reads 0 and `gp_cmp` does not set fault bit 6.
- R6: Fault bits are sticky and change only through a write to address 1. Such a write clears each bit written as 0 and keeps each bit written as 1. A set event in the same cycle takes priority over the clear.
- R7: `alert_n` is low exactly when some fault bit and the alert-enable bit at the same position are both 1.
- R8: Control bits 7:6 set the general-purpose pin mode. With 2'b00, `gp_oe` equals `pg2_ready` and `gp_out` is 0. With 2'b01, `gp_oe` is the inverse of `pg2_ready` and `gp_out` is 0. With 2'b10, `gp_oe` is 1 and `gp_out` equals alert-enable bit 6. With 2'b11, `gp_oe` is 0.
- R9: `gate_on` equals control bit 3, and a write to address 3 updates it on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dflt_on | input | 1 | Strap giving the reset value of the gate command |
| en_pin | input | 1 | Asynchronous enable input |
| flt_pin | input | 1 | Asynchronous external fault input |
| gp_cmp | input | 1 | Comparator result of the general-purpose pin |
| pg2_ready | input | 1 | Second power-good indication |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 8 | Read data |
| gp_oe | output | 1 | General-purpose pin driver enable |
| gp_out | output | 1 | General-purpose pin driven value |
| gate_on | output | 1 | Pass-device gate command |
| alert_n | output | 1 | Active-low alert |

## Verification
The hardest case to reach is a fault clear that coincides with a set event. The event source has to be held active while software writes zero to the fault register, and the bench has to show that the bit survives. The stimulus leaves the fault pin high through a clearing write. It then lowers the pin and confirms that the bit is still latched while the status bit has dropped. A partial clear with a mixed mask is also driven; it uses a fault register that holds both an enable-change event and a general-purpose event at once. That state only exists after input mode is selected and two unrelated inputs have been moved in turn.

// File: rtl/hsc_monitor_regs.sv
module hsc_monitor_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dflt_on,
  input  logic       en_pin,
  input  logic       flt_pin,
  input  logic       gp_cmp,
  input  logic       pg2_ready,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       gp_oe,
  output logic       gp_out,
  output logic       gate_on,
  output logic       alert_n
);

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_FLT  = 2'd1;
  localparam logic [1:0] A_AEN  = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;

  logic [1:0] en_sy, flt_sy, gp_sy;
  logic       en_prev;
  logic [7:0] fault_q, aen_q, ctrl_q;
  logic [7:0] status, fault_set, rd_mux;
  logic       gp_in_mode, en_chg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_sy   <= '0;
      flt_sy  <= '0;
      gp_sy   <= '0;
      en_prev <= 1'b0;
    end else begin
      en_sy   <= {en_sy[0], en_pin};
      flt_sy  <= {flt_sy[0], flt_pin};
      gp_sy   <= {gp_sy[0], gp_cmp};
      en_prev <= en_sy[1];
    end
  end

  assign gp_in_mode = (ctrl_q[7:6] == 2'b11);
  assign en_chg     = en_sy[1] ^ en_prev;
  assign status     = {flt_sy[1], gp_in_mode & gp_sy[1], 1'b0, en_sy[1], 4'b0};
  assign fault_set  = {flt_sy[1], gp_in_mode & gp_sy[1], 1'b0, en_chg, 4'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= '0;
      aen_q   <= '0;
      ctrl_q  <= {4'b0, dflt_on, 3'b0};
    end else begin
      if (reg_wr && reg_addr == A_FLT) fault_q <= (fault_q & reg_wdata) | fault_set;
      else                             fault_q <= fault_q | fault_set;
      if (reg_wr && reg_addr == A_AEN)  aen_q  <= reg_wdata;
      if (reg_wr && reg_addr == A_CTRL) ctrl_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  rd_mux = status;
      A_FLT:   rd_mux = fault_q;
      A_AEN:   rd_mux = aen_q;
      default: rd_mux = ctrl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rd_data <= rd_mux;
    end
  end

  always_comb begin
    gp_oe  = 1'b0;
    gp_out = 1'b0;
    case (ctrl_q[7:6])
      2'b00:   gp_oe = pg2_ready;
      2'b01:   gp_oe = ~pg2_ready;
      2'b10: begin
        gp_oe  = 1'b1;
        gp_out = aen_q[6];
      end
      default: gp_oe = 1'b0;
    endcase
  end

  assign gate_on = ctrl_q[3];
  assign alert_n = ~|(fault_q & aen_q);

  // R6
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_FLT) |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

  // R3
  en_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_sy[1] != en_prev) |=> fault_q[4]);

  // R7
  alert_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q == 8'h00) |-> alert_n);

  // R9
  gate_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL) |=> (gate_on == $past(reg_wdata[3])));

  // R8
  gp_input_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7:6] == 2'b11) |-> !gp_oe);

  // R2
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid);

endmodule

// File: tb/hsc_monitor_regs_tb_top.sv
`timescale 1ns/1ps
module hsc_monitor_regs_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dflt_on = 1'b1;
  logic       en_pin = 1'b0, flt_pin = 1'b0, gp_cmp = 1'b0, pg2_ready = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       rd_valid, gp_oe, gp_out, gate_on, alert_n;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  hsc_monitor_regs dut_i (
    .clk(clk), .rst_n(rst_n), .dflt_on(dflt_on), .en_pin(en_pin),
    .flt_pin(flt_pin), .gp_cmp(gp_cmp), .pg2_ready(pg2_ready),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .gp_oe(gp_oe), .gp_out(gp_out), .gate_on(gate_on), .alert_n(alert_n)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected read data %h expected none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rd_data, e);
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    chk("R1 alert_n in reset", {7'b0, alert_n}, 8'h01);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 alert_n", {7'b0, alert_n}, 8'h01);
    chk("R9 gate default on", {7'b0, gate_on}, 8'h01);
    rd_exp(2'd0, 8'h00, "R1 status");
    rd_exp(2'd1, 8'h00, "R1 fault");
    rd_exp(2'd2, 8'h00, "R1 alert-enable");
    rd_exp(2'd3, 8'h08, "R1 control");

    wr(2'd3, 8'h00);
    chk("R9 gate off", {7'b0, gate_on}, 8'h00);
    wr(2'd3, 8'h08);
    chk("R9 gate on", {7'b0, gate_on}, 8'h01);

    en_pin = 1'b1;
    wait_cyc(4);
    rd_exp(2'd0, 8'h10, "R2 status enable high");
    rd_exp(2'd1, 8'h10, "R3 rising enable fault");
    chk("R7 masked alert", {7'b0, alert_n}, 8'h01);
    wr(2'd2, 8'h10);
    chk("R7 enabled alert", {7'b0, alert_n}, 8'h00);
    wr(2'd1, 8'h00);
    chk("R7 alert after clear", {7'b0, alert_n}, 8'h01);
    rd_exp(2'd1, 8'h00, "R6 fault cleared");

    en_pin = 1'b0;
    wait_cyc(4);
    rd_exp(2'd1, 8'h10, "R3 falling enable fault");
    chk("R7 alert on falling", {7'b0, alert_n}, 8'h00);
    wr(2'd1, 8'hEF);
    rd_exp(2'd1, 8'h00, "R6 clear bit4 by zero");

    flt_pin = 1'b1;
    wait_cyc(4);
    rd_exp(2'd0, 8'h80, "R4 status fault level");
    rd_exp(2'd1, 8'h80, "R4 fault bit7");
    chk("R7 bit7 masked", {7'b0, alert_n}, 8'h01);
    wr(2'd2, 8'h90);
    chk("R7 bit7 alert", {7'b0, alert_n}, 8'h00);
    wr(2'd1, 8'h00);
    rd_exp(2'd1, 8'h80, "R6 set wins over clear");
    flt_pin = 1'b0;
    wait_cyc(4);
    rd_exp(2'd0, 8'h00, "R4 status fault low");
    rd_exp(2'd1, 8'h80, "R6 fault sticky");
    wr(2'd1, 8'h00);
    rd_exp(2'd1, 8'h00, "R6 fault cleared");
    chk("R7 alert released", {7'b0, alert_n}, 8'h01);
    wr(2'd2, 8'h00);

    pg2_ready = 1'b0;
    wait_cyc(1);
    chk("R8 mode0 not ready oe", {6'b0, gp_oe, gp_out}, 8'h00);
    pg2_ready = 1'b1;
    wait_cyc(1);
    chk("R8 mode0 ready pull low", {6'b0, gp_oe, gp_out}, 8'h02);
    gp_cmp = 1'b1;
    wait_cyc(4);
    rd_exp(2'd0, 8'h00, "R5 status6 off outside input mode");
    rd_exp(2'd1, 8'h00, "R5 no fault6 outside input mode");

    wr(2'd3, 8'h48);
    chk("R8 mode1 ready float", {6'b0, gp_oe, gp_out}, 8'h00);
    pg2_ready = 1'b0;
    wait_cyc(1);
    chk("R8 mode1 not ready pull low", {6'b0, gp_oe, gp_out}, 8'h02);

    wr(2'd3, 8'h88);
    chk("R8 mode2 drive low", {6'b0, gp_oe, gp_out}, 8'h02);
    wr(2'd2, 8'h40);
    chk("R8 mode2 drive high", {6'b0, gp_oe, gp_out}, 8'h03);
    rd_exp(2'd1, 8'h00, "R5 no fault6 in output mode");
    wr(2'd2, 8'h00);

    wr(2'd3, 8'hC8);
    chk("R8 mode3 input", {6'b0, gp_oe, gp_out}, 8'h00);
    wait_cyc(1);
    rd_exp(2'd0, 8'h40, "R5 status6 high");
    rd_exp(2'd1, 8'h40, "R5 fault6 set");
    gp_cmp = 1'b0;
    wait_cyc(4);
    rd_exp(2'd0, 8'h00, "R5 status6 clears");
    rd_exp(2'd1, 8'h40, "R5 fault6 stays");
    wr(2'd2, 8'h40);
    chk("R7 bit6 alert", {7'b0, alert_n}, 8'h00);
    wr(2'd2, 8'h00);

    en_pin = 1'b1;
    wait_cyc(4);
    rd_exp(2'd1, 8'h50, "R3 two faults held");
    wr(2'd1, 8'h40);
    rd_exp(2'd1, 8'h40, "R6 partial clear keeps ones");
    wr(2'd1, 8'h00);
    rd_exp(2'd1, 8'h00, "R6 final clear");
    rd_exp(2'd3, 8'hC8, "R9 control readback");

    wait_cyc(4);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: got %0d pending reads expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule